// File: doc/BRIEF.md
# Converter Serial Readout Port

This block models the device side of the serial port of a multichannel delta-sigma converter. A cycle counter stands in for the analog conversion. The block cycles through three states: converting, sleeping with a result ready, and shifting out a result frame. A host frames each access with an active-low chip select and supplies the serial clock. Through the data-out line it sees either the end-of-conversion flag or the result bits. During the same frame it shifts a new channel address in on the data-in line.

All serial inputs are brought into the system clock domain through two flip-flop synchronisers. Edges are detected there, so the serial clock must stay well below the system clock. The value reported for each conversion comes from a test input. It is captured at the moment the conversion finishes. Leaving the chip select low after a frame lets the host use the end-of-conversion flag as a ready interrupt. Raising chip select in mid-frame abandons the readout and restarts conversion.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the block is converting, `chan_sel` is 0, and with `cs_n` high `sdo_oe` is 0.
- R2: `sdo_oe` follows the inverse of `cs_n` within 3 system clocks. When it is 0 the data-out line is treated as high-impedance.
- R3: With `cs_n` low and no frame in progress, `sdo` is 1 while a conversion runs. It becomes 0 once `CONV_CYCLES` system clocks have passed since the conversion started.
- R4: A frame is `RES_W+3` bits, valid at successive rising `sck` edges. The bits are, in order: end-of-conversion (0), a fixed 0, the sign (`test_value` MSB), then the remaining `RES_W` bits of `test_value` MSB first. Each bit is updated after a falling `sck` edge.
- R5: `test_value` is captured when a conversion ends. Later changes to it do not alter the frame that follows.
- R6: The last falling `sck` edge of a frame starts a new conversion, and `sdo` returns to 1. `sdo` falls to 0 again `CONV_CYCLES` clocks later.
- R7: `sdi` is sampled on the first `ADDR_W` rising `sck` edges of a frame, MSB first, with the last of these bits being the LSB. A complete address appears on `chan_sel` when the next conversion starts.
- R8: A rising `cs_n` after the first rising `sck` edge of a frame and before its final falling edge ends the frame and starts a new conversion at once. When `cs_n` is lowered again, `sdo` reads 1.
- R9: If such an abort comes before the LSB of the address has been sampled, `chan_sel` keeps its old value. If it comes after, the new address is applied.
- R10: `sck` edges are ignored while converting and while `cs_n` is high. They neither start a frame nor change `chan_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial address input |
| test_value | input | RES_W+1 | Result presented by the stand-in converter, sign in the MSB |
| sdo | output | 1 | Serial data / end-of-conversion flag |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high-impedance |
| chan_sel | output | ADDR_W | Channel address in use by the current conversion |

## Verification
A wrong state shows at `sdo` within a few clocks of the next synchronised `sck` edge. A block stuck converting never drops the flag. A block that leaves the data state early or late shifts every later bit of the frame against what the scoreboard expects. A mishandled abort shows up in two places: as a 0 instead of 1 on `sdo` when chip select returns low, or as a `chan_sel` that changed when it should not have. A bad capture point shows as the frame carrying a value that the test input held after the conversion finished.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W       = 16,
  parameter int ADDR_W      = 5,
  parameter int CONV_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic [RES_W:0]    test_value,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] chan_sel
);
  localparam int FRAME = RES_W + 3;
  localparam int FCW   = $clog2(FRAME + 1);
  localparam int TCW   = $clog2(CONV_CYCLES + 1);
  localparam logic [FCW-1:0] ADDR_LAST  = FCW'(ADDR_W - 1);
  localparam logic [FCW-1:0] ADDR_CNT   = FCW'(ADDR_W);
  localparam logic [FCW-1:0] FRAME_LAST = FCW'(FRAME - 1);
  localparam logic [TCW-1:0] CONV_LAST  = TCW'(CONV_CYCLES - 1);

  typedef enum logic [1:0] {ST_CONV, ST_SLEEP, ST_DATA} state_t;

  state_t              state;
  logic [1:0]          sck_s, cs_s, sdi_s;
  logic                sck_q, cs_q;
  logic [TCW-1:0]      tmr;
  logic [FCW-1:0]      nrise, nfall;
  logic [FRAME-1:0]    shreg;
  logic [ADDR_W-1:0]   addr_sh;
  logic                addr_ok;

  wire sck_rise = sck_s[1] & ~sck_q;
  wire sck_fall = ~sck_s[1] & sck_q;
  wire cs_rise  = cs_s[1] & ~cs_q;
  wire sel      = ~cs_s[1];

  assign sdo_oe = sel;
  assign sdo    = (state == ST_DATA) ? shreg[FRAME-1] : (state == ST_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; sck_q <= 1'b0;
      cs_s  <= '1; cs_q  <= 1'b1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[0], sck};   sck_q <= sck_s[1];
      cs_s  <= {cs_s[0], cs_n};   cs_q  <= cs_s[1];
      sdi_s <= {sdi_s[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CONV;
      tmr      <= '0;
      nrise    <= '0;
      nfall    <= '0;
      shreg    <= '0;
      addr_sh  <= '0;
      addr_ok  <= 1'b0;
      chan_sel <= '0;
    end else begin
      case (state)
        ST_CONV: begin
          if (tmr == CONV_LAST) begin
            tmr   <= '0;
            state <= ST_SLEEP;
            shreg <= {2'b00, test_value};
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (sel && sck_rise) begin
            state   <= ST_DATA;
            nrise   <= FCW'(1);
            nfall   <= '0;
            addr_sh <= {addr_sh[ADDR_W-2:0], sdi_s[1]};
            addr_ok <= (ADDR_W == 1);
          end
        end
        ST_DATA: begin
          if (cs_rise) begin
            state   <= ST_CONV;
            tmr     <= '0;
            addr_ok <= 1'b0;
            if (addr_ok) chan_sel <= addr_sh;
          end else if (sel) begin
            if (sck_rise && nrise < ADDR_CNT) begin
              addr_sh <= {addr_sh[ADDR_W-2:0], sdi_s[1]};
              nrise   <= nrise + 1'b1;
              if (nrise == ADDR_LAST) addr_ok <= 1'b1;
            end
            if (sck_fall) begin
              shreg <= {shreg[FRAME-2:0], 1'b0};
              nfall <= nfall + 1'b1;
              if (nfall == FRAME_LAST) begin
                state   <= ST_CONV;
                tmr     <= '0;
                addr_ok <= 1'b0;
                if (addr_ok) chan_sel <= addr_sh;
              end
            end
          end
        end
        default: state <= ST_CONV;
      endcase
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= CONV_LAST) else $error("timer overrun"); // R3

  AST_FRAME_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_SLEEP)
    else $error("frame entered from wrong state"); // R10

  AST_FALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DATA |-> nfall < FCW'(FRAME))
    else $error("frame longer than allowed"); // R6

  AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_DATA && $past(cs_rise)) |-> state == ST_CONV)
    else $error("abort did not restart conversion"); // R8

  AST_CHAN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_sel) |-> (state == ST_CONV && $past(state) == ST_DATA))
    else $error("channel changed outside conversion start"); // R9

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !sel) |=> state != ST_DATA)
    else $error("frame started while deselected"); // R10
endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W  = 16;
  localparam int ADDR_W = 5;
  localparam int CONV   = 64;
  localparam int FRAME  = RES_W + 3;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [RES_W:0] test_value;
  logic sdo, sdo_oe;
  logic [ADDR_W-1:0] chan_sel;

  int checks = 0, fails = 0;
  logic  exp_q[$];
  string tag_q[$];

  adc_serial_port #(.RES_W(RES_W), .ADDR_W(ADDR_W), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .test_value(test_value), .sdo(sdo), .sdo_oe(sdo_oe), .chan_sel(chan_sel));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge sck) begin
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {31'd0, sdo}, {31'd0, e});
    end
  end

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_frame(logic [ADDR_W-1:0] addr, int nr, logic [RES_W:0] val, string tag);
    logic [FRAME-1:0] f;
    f = {2'b00, val};
    for (int i = 0; i < nr; i++) begin
      exp_q.push_back(f[FRAME-1-i]);
      tag_q.push_back(tag);
    end
    cs_n = 1'b0;
    clks(6);
    for (int i = 0; i < nr; i++) begin
      sdi = (i < ADDR_W) ? addr[ADDR_W-1-i] : 1'b0;
      clks(4);
      sck = 1'b1;
      clks(8);
      if (i == nr - 1 && nr < FRAME) begin
        cs_n = 1'b1;
        clks(6);
      end
      sck = 1'b0;
      clks(4);
    end
  endtask

  task automatic toggle_sck(int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'b1; clks(8); sck = 1'b1; clks(8); sck = 1'b0;
    end
    sdi = 1'b0;
  endtask

  initial begin
    clks(200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    test_value = 17'h0A5C3;
    clks(5);
    rst_n = 1'b1;
    chk("R1 oe", {31'd0, sdo_oe}, 0);
    chk("R1 chan", {27'd0, chan_sel}, 0);
    cs_n = 1'b0; clks(4);
    chk("R2 oe low cs", {31'd0, sdo_oe}, 1);
    chk("R3 busy", {31'd0, sdo}, 1);
    clks(CONV + 10);
    chk("R3 ready", {31'd0, sdo}, 0);
    cs_n = 1'b1; clks(4);
    chk("R2 hiz", {31'd0, sdo_oe}, 0);
    test_value = 17'h13F0F;
    read_frame(5'b10110, FRAME, 17'h0A5C3, "R4/R5 frame");
    clks(4);
    chk("R6 restart", {31'd0, sdo}, 1);
    chk("R7 addr", {27'd0, chan_sel}, 5'b10110);
    toggle_sck(3);
    clks(CONV + 10);
    chk("R6 ready again", {31'd0, sdo}, 0);
    chk("R10 chan kept", {27'd0, chan_sel}, 5'b10110);
    cs_n = 1'b1; clks(4);
    toggle_sck(2);
    read_frame(5'b01001, FRAME, 17'h13F0F, "R10 frame");
    clks(4);
    chk("R7 addr2", {27'd0, chan_sel}, 5'b01001);
    test_value = 17'h00FF1;
    clks(CONV + 10);
    read_frame(5'b11111, 3, 17'h00FF1, "R8 partial");
    cs_n = 1'b0; clks(4);
    chk("R8 busy after abort", {31'd0, sdo}, 1);
    chk("R9 addr kept", {27'd0, chan_sel}, 5'b01001);
    clks(CONV + 10);
    chk("R8 ready", {31'd0, sdo}, 0);
    read_frame(5'b00011, 7, 17'h00FF1, "R8 partial2");
    clks(4);
    chk("R9 addr taken", {27'd0, chan_sel}, 5'b00011);
    cs_n = 1'b0; clks(4);
    chk("R8 busy2", {31'd0, sdo}, 1);
    test_value = 17'h18001;
    clks(CONV + 10);
    read_frame(5'b11100, FRAME, 17'h18001, "R4 negative");
    clks(4);
    chk("R7 addr3", {27'd0, chan_sel}, 5'b11100);
    chk("R6 busy3", {31'd0, sdo}, 1);
    clks(20);
    chk("R4 queue drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule